// File: doc/BRIEF.md
# Adaptive Three-Zone PI Loop Filter

This block is the loop filter of an all-digital phase-locked loop. Once per reference cycle it receives a signed phase-error sample, counted in system clock ticks, and returns a new frequency control word for the numerically controlled oscillator. The new word is the base control word plus a proportional term and an integral term, both derived from the error.

The gains are not fixed. The magnitude of each sample places the loop in one of three capture zones. A large error selects the fast zone, which uses strong gains to shorten acquisition. A medium error selects the transition zone. A small error selects the slow zone, which uses weak gains to reject noise. Two run-time thresholds set the zone boundaries. Each gain is a power of two, implemented as an arithmetic right shift. Both the integrator and the output word saturate and never wrap.

Top module: `apll_zone_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the integrator clears, `cw_out` takes the value of `base_word`, `cw_valid` is 0 and `zone_out` is 0 after that edge.
- R2: Each cycle with `err_valid` high produces exactly one cycle with `cw_valid` high, on the following cycle. `cw_valid` is low after a cycle without `err_valid`.
- R3: In cycles with `err_valid` low, `cw_out`, `zone_out` and the integrator do not change.
- R4: Let |e| be the magnitude of the error. The zone code on `zone_out` is 2 (fast) when |e| >= `fast_thr`, 1 (transition) when `slow_thr` <= |e| < `fast_thr`, and 0 (slow) otherwise. It is reported together with the word for that sample.
- R5: The proportional term is e arithmetically right-shifted (floor) by the zone's P shift. The defaults are fast 0, transition 2 and slow 4.
- R6: The integrator adds e arithmetically right-shifted by the zone's I shift, with defaults fast 2, transition 4 and slow 6. The output is `base_word` + proportional term + the updated integrator.
- R7: The integrator saturates at +/-`INT_LIM` (default 2048) and never wraps.
- R8: `cw_out` saturates to the range [`word_min`, `word_max`].
- R9: The thresholds are sampled together with each error sample, so a change to them takes effect on the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| err_valid | input | 1 | Phase-error sample strobe |
| err_in | input | ERR_W | Signed phase error in clock ticks |
| base_word | input | CW_W | Nominal control word |
| fast_thr | input | ERR_W | Lowest magnitude of the fast zone |
| slow_thr | input | ERR_W | Lowest magnitude of the transition zone |
| word_min | input | CW_W | Lower output limit |
| word_max | input | CW_W | Upper output limit |
| cw_out | output | CW_W | Control word to the oscillator |
| cw_valid | output | 1 | One-cycle strobe for a new word |
| zone_out | output | 2 | Zone of the last sample |

## Verification
The bound checker checks the following relations on every cycle:
- one-cycle latency of `cw_valid` and its single pulse per sample;
- that `cw_out` and `zone_out` hold when no sample arrives;
- the reset value;
- that the output stays inside the limits;
- that a fast-zone code appears exactly when the error magnitude reaches the fast threshold.

The arithmetic can only be shown by the bench's scenarios, which compare against a model built from the requirements. This covers the floor-rounded shifts per zone, integrator accumulation and its clamping with no wrap, the exact threshold boundaries, run-time threshold changes and integrator clearing on reset.

// File: rtl/apll_filt_pkg.sv
package apll_filt_pkg;

    typedef enum logic [1:0] {
        ZN_SLOW  = 2'd0,
        ZN_TRANS = 2'd1,
        ZN_FAST  = 2'd2
    } zone_e;

endpackage

// File: rtl/apll_zone_classify.sv
module apll_zone_classify
    import apll_filt_pkg::*;
#(
    parameter int ERR_W = 16
) (
    input  logic signed [ERR_W-1:0] err,
    input  logic [ERR_W-1:0]        fast_thr,
    input  logic [ERR_W-1:0]        slow_thr,
    output zone_e                   zone
);
    logic [ERR_W-1:0] mag;

    always_comb begin
        // two's complement negate; the most negative value maps to 2^(ERR_W-1)
        mag = err[ERR_W-1] ? (~err + 1'b1) : err;
        if (mag >= fast_thr)      zone = ZN_FAST;
        else if (mag >= slow_thr) zone = ZN_TRANS;
        else                      zone = ZN_SLOW;
    end
endmodule

// File: rtl/apll_gain_shift.sv
module apll_gain_shift
    import apll_filt_pkg::*;
#(
    parameter int ERR_W    = 16,
    parameter int SH_W     = 5,
    parameter int KP_FAST  = 0,
    parameter int KP_TRANS = 2,
    parameter int KP_SLOW  = 4,
    parameter int KI_FAST  = 2,
    parameter int KI_TRANS = 4,
    parameter int KI_SLOW  = 6
) (
    input  zone_e                   zone,
    input  logic signed [ERR_W-1:0] err,
    output logic signed [ERR_W-1:0] p_term,
    output logic signed [ERR_W-1:0] i_term
);
    localparam int NZ = 3;
    logic [SH_W-1:0] kp_tab [NZ];
    logic [SH_W-1:0] ki_tab [NZ];

    // one shift pair per zone, indexed by the zone code
    for (genvar z = 0; z < NZ; z++) begin : g_tab
        localparam int KP = (z == 2) ? KP_FAST : (z == 1) ? KP_TRANS : KP_SLOW;
        localparam int KI = (z == 2) ? KI_FAST : (z == 1) ? KI_TRANS : KI_SLOW;
        assign kp_tab[z] = SH_W'(KP);
        assign ki_tab[z] = SH_W'(KI);
    end

    logic [SH_W-1:0] kp_sel, ki_sel;

    always_comb begin
        kp_sel = kp_tab[0];
        ki_sel = ki_tab[0];
        for (int z = 0; z < NZ; z++) begin
            if (zone == zone_e'(z)) begin
                kp_sel = kp_tab[z];
                ki_sel = ki_tab[z];
            end
        end
        p_term = err >>> kp_sel;
        i_term = err >>> ki_sel;
    end
endmodule

// File: rtl/apll_clamp.sv
module apll_clamp #(
    parameter int W     = 26,
    parameter int OUT_W = 24
) (
    input  logic signed [W-1:0] x,
    input  logic signed [W-1:0] lo,
    input  logic signed [W-1:0] hi,
    output logic [OUT_W-1:0]    y
);
    logic under, over;

    always_comb begin
        under = (x < lo);
        over  = (x > hi);
        if (under)     y = lo[OUT_W-1:0];
        else if (over) y = hi[OUT_W-1:0];
        else           y = x[OUT_W-1:0];
    end
endmodule

// File: rtl/apll_zone_filter.sv
module apll_zone_filter
    import apll_filt_pkg::*;
#(
    parameter int ERR_W    = 16,
    parameter int CW_W     = 32,
    parameter int INT_W    = 24,
    parameter int INT_LIM  = 2048,
    parameter int SH_W     = 5,
    parameter int KP_FAST  = 0,
    parameter int KP_TRANS = 2,
    parameter int KP_SLOW  = 4,
    parameter int KI_FAST  = 2,
    parameter int KI_TRANS = 4,
    parameter int KI_SLOW  = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    err_valid,
    input  logic signed [ERR_W-1:0] err_in,
    input  logic [CW_W-1:0]         base_word,
    input  logic [ERR_W-1:0]        fast_thr,
    input  logic [ERR_W-1:0]        slow_thr,
    input  logic [CW_W-1:0]         word_min,
    input  logic [CW_W-1:0]         word_max,
    output logic [CW_W-1:0]         cw_out,
    output logic                    cw_valid,
    output logic [1:0]              zone_out
);
    localparam int IW1   = INT_W + 1;
    localparam int SUM_W = CW_W + 2;
    localparam logic signed [IW1-1:0] INT_HI = IW1'(INT_LIM);
    localparam logic signed [IW1-1:0] INT_LO = -INT_HI;

    typedef struct packed {
        logic signed [INT_W-1:0] integ;
        logic [CW_W-1:0]         cw;
        logic                    vld;
        zone_e                   zone;
    } state_t;

    state_t st_d, st_q;

    zone_e                   zone_d;
    logic signed [ERR_W-1:0] p_term, i_term;
    logic signed [IW1-1:0]   integ_sum;
    logic [INT_W-1:0]        integ_new;
    logic signed [SUM_W-1:0] word_sum, word_lo, word_hi;
    logic [CW_W-1:0]         word_new;

    apll_zone_classify #(.ERR_W(ERR_W)) u_cls (
        .err      (err_in),
        .fast_thr (fast_thr),
        .slow_thr (slow_thr),
        .zone     (zone_d)
    );

    apll_gain_shift #(
        .ERR_W(ERR_W), .SH_W(SH_W),
        .KP_FAST(KP_FAST), .KP_TRANS(KP_TRANS), .KP_SLOW(KP_SLOW),
        .KI_FAST(KI_FAST), .KI_TRANS(KI_TRANS), .KI_SLOW(KI_SLOW)
    ) u_gain (
        .zone   (zone_d),
        .err    (err_in),
        .p_term (p_term),
        .i_term (i_term)
    );

    always_comb begin
        integ_sum = $signed({st_q.integ[INT_W-1], st_q.integ})
                  + $signed({{(IW1-ERR_W){i_term[ERR_W-1]}}, i_term});
    end

    apll_clamp #(.W(IW1), .OUT_W(INT_W)) u_int_clamp (
        .x  (integ_sum),
        .lo (INT_LO),
        .hi (INT_HI),
        .y  (integ_new)
    );

    always_comb begin
        word_sum = $signed({2'b00, base_word})
                 + $signed({{(SUM_W-ERR_W){p_term[ERR_W-1]}}, p_term})
                 + $signed({{(SUM_W-INT_W){integ_new[INT_W-1]}}, integ_new});
        word_lo  = $signed({2'b00, word_min});
        word_hi  = $signed({2'b00, word_max});
    end

    apll_clamp #(.W(SUM_W), .OUT_W(CW_W)) u_out_clamp (
        .x  (word_sum),
        .lo (word_lo),
        .hi (word_hi),
        .y  (word_new)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (err_valid) begin
            st_d.integ = $signed(integ_new);
            st_d.cw    = word_new;
            st_d.vld   = 1'b1;
            st_d.zone  = zone_d;
        end
        if (rst) begin
            st_d.integ = '0;
            st_d.cw    = base_word;
            st_d.vld   = 1'b0;
            st_d.zone  = ZN_SLOW;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cw_out   = st_q.cw;
    assign cw_valid = st_q.vld;
    assign zone_out = st_q.zone;
endmodule

// File: rtl/apll_zone_filter_chk.sv
module apll_zone_filter_chk #(
    parameter int ERR_W = 16,
    parameter int CW_W  = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    err_valid,
    input logic signed [ERR_W-1:0] err_in,
    input logic [CW_W-1:0]         base_word,
    input logic [ERR_W-1:0]        fast_thr,
    input logic [CW_W-1:0]         word_min,
    input logic [CW_W-1:0]         word_max,
    input logic [CW_W-1:0]         cw_out,
    input logic                    cw_valid,
    input logic [1:0]              zone_out
);
    logic [ERR_W-1:0] err_mag;
    assign err_mag = err_in[ERR_W-1] ? (~err_in + 1'b1) : err_in;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (cw_out == $past(base_word)) && !cw_valid && (zone_out == 2'd0));

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> cw_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !err_valid |=> !cw_valid);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !err_valid |=> $stable(cw_out) && $stable(zone_out));

    p_fast_zone_r4: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> ((zone_out == 2'd2) == ($past(err_mag) >= $past(fast_thr))));

    p_out_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (err_valid && (word_min <= word_max))
        |=> (cw_out >= $past(word_min)) && (cw_out <= $past(word_max)));
endmodule

bind apll_zone_filter apll_zone_filter_chk #(.ERR_W(ERR_W), .CW_W(CW_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .err_valid (err_valid),
    .err_in    (err_in),
    .base_word (base_word),
    .fast_thr  (fast_thr),
    .word_min  (word_min),
    .word_max  (word_max),
    .cw_out    (cw_out),
    .cw_valid  (cw_valid),
    .zone_out  (zone_out)
);

// File: tb/apll_zone_filter_test.sv
module apll_zone_filter_test;
    localparam int ERR_W = 16;
    localparam int CW_W  = 32;
    localparam longint LIM = 2048;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    err_valid = 1'b0;
    logic signed [ERR_W-1:0] err_in = '0;
    logic [CW_W-1:0]         base_word = 32'h1000_0000;
    logic [ERR_W-1:0]        fast_thr = 16'd64;
    logic [ERR_W-1:0]        slow_thr = 16'd8;
    logic [CW_W-1:0]         word_min = 32'd0;
    logic [CW_W-1:0]         word_max = 32'hFFFF_FFFF;
    logic [CW_W-1:0]         cw_out;
    logic                    cw_valid;
    logic [1:0]              zone_out;

    apll_zone_filter uut (
        .clk(clk), .rst(rst), .err_valid(err_valid), .err_in(err_in),
        .base_word(base_word), .fast_thr(fast_thr), .slow_thr(slow_thr),
        .word_min(word_min), .word_max(word_max),
        .cw_out(cw_out), .cw_valid(cw_valid), .zone_out(zone_out)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    longint m_integ = 0;
    longint m_cw = 0;

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint clampv(input longint v, input longint lo, input longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // one valid sample; checks word, zone, strobe, then the idle cycle after it
    task automatic sample(input int e, input string req);
        longint mag, p, inc;
        int z, kp, ki;
        @(negedge clk);
        err_in = ERR_W'(e);
        err_valid = 1'b1;
        mag = (e < 0) ? -e : e;
        z = (mag >= fast_thr) ? 2 : (mag >= slow_thr) ? 1 : 0;
        kp = (z == 2) ? 0 : (z == 1) ? 2 : 4;
        ki = (z == 2) ? 2 : (z == 1) ? 4 : 6;
        p   = longint'(e) >>> kp;
        inc = longint'(e) >>> ki;
        m_integ = clampv(m_integ + inc, -LIM, LIM);
        m_cw = clampv(longint'(base_word) + p + m_integ,
                      longint'(word_min), longint'(word_max));
        @(negedge clk);
        err_valid = 1'b0;
        check({req, " word"}, longint'(cw_out), m_cw);
        check({req, " zone"}, longint'(zone_out), z);
        check("R2 strobe", longint'(cw_valid), 1);
        @(negedge clk);
        check("R2 single pulse", longint'(cw_valid), 0);
        check("R3 hold", longint'(cw_out), m_cw);
    endtask

    task automatic t_reset(input longint base);
        @(negedge clk);
        base_word = CW_W'(base);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_integ = 0;
        check("R1 word", longint'(cw_out), base);
        check("R1 strobe", longint'(cw_valid), 0);
        check("R1 zone", longint'(zone_out), 0);
    endtask

    task automatic t_zones;
        sample(100, "R4 R5 R6 fast");
        sample(-20, "R4 R5 R6 transition");
        sample(5,   "R4 R5 R6 slow");
        sample(-3,  "R5 R6 floor shift");
    endtask

    task automatic t_boundaries;
        sample(64,  "R4 at fast threshold");
        sample(63,  "R4 below fast threshold");
        sample(-64, "R4 negative fast threshold");
        sample(8,   "R4 at slow threshold");
        sample(7,   "R4 below slow threshold");
    endtask

    task automatic t_thresholds;
        @(negedge clk);
        fast_thr = 16'd16;
        slow_thr = 16'd4;
        sample(20, "R9 new fast threshold");
        sample(4,  "R9 new slow threshold");
        @(negedge clk);
        fast_thr = 16'd64;
        slow_thr = 16'd8;
    endtask

    task automatic t_idle;
        longint held;
        held = longint'(cw_out);
        @(negedge clk);
        err_in = 16'sd500;
        repeat (5) @(negedge clk);
        check("R3 idle word", longint'(cw_out), held);
        check("R3 idle strobe", longint'(cw_valid), 0);
        sample(10, "R3 integrator untouched by idle");
    endtask

    task automatic t_int_sat;
        for (int k = 0; k < 4; k++) sample(4000, "R7 positive clamp");
        sample(-30000, "R7 negative clamp no wrap");
        sample(-32768, "R7 most negative error");
    endtask

    task automatic t_out_sat;
        @(negedge clk);
        word_max = base_word + 32'd50;
        sample(3000, "R8 upper limit");
        @(negedge clk);
        word_min = base_word + 32'd10000;
        word_max = base_word + 32'd20000;
        sample(-10, "R8 lower limit");
        @(negedge clk);
        word_min = 32'd0;
        word_max = 32'hFFFF_FFFF;
    endtask

    task automatic t_reset_clear;
        sample(4000, "R6 preload");
        t_reset(32'h2000_0000);
        sample(-3, "R1 integrator cleared");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 word", longint'(cw_out), 32'h1000_0000);
        check("R1 strobe", longint'(cw_valid), 0);
        check("R1 zone", longint'(zone_out), 0);
        t_zones();
        t_boundaries();
        t_thresholds();
        t_idle();
        t_int_sat();
        t_out_sat();
        t_reset_clear();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule